// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic, logic and shift datapath of a small 16-bit accumulator processor. Each cycle it takes the current value of a destination register, a second operand and a 4-bit operation code. It returns three things:

- the operation's result;
- a write enable telling the surrounding datapath whether to store that result;
- the four condition flags (negative, zero, overflow, carry) as they stand after the operation, with a per-flag update mask.

The datapath is purely combinational. A small registered flag file holds the machine's condition flags. When the flag strobe is high at a rising clock edge, the flag file loads the flags named by the update mask and keeps the rest. Rotates and the flag-packing operation read the stored flags.

Each operation touches its own subset of the flags:

- Compare computes a difference, updates the flags and then discards the difference.
- Rotates move bits through the stored carry.
- The flag-packing operation turns the stored flags into a register value.

Operand fetch, addressing and memory traffic belong to the surrounding processor.

Top module: `acc_alu_unit`

Operation codes on `op_i`:

| Code | Operation |
|------|-----------|
| 0 | add |
| 1 | subtract |
| 2 | AND |
| 3 | OR |
| 4 | compare |
| 5 | invert |
| 6 | negate |
| 7 | arithmetic shift left |
| 8 | arithmetic shift right |
| 9 | rotate left |
| 10 | rotate right |
| 11 | pack flags |
| 12–15 | reserved |

Flag vectors and masks are ordered {N,Z,V,C} in bits [3:0], so N is bit 3 and C is bit 0. Bit 15 is the most significant bit.

## Requirements
- R1: Add (code 0) gives reg+opnd modulo 2^16 with write enable high. It updates all four flags. V is set when both inputs share a sign and the result's sign differs. C is the carry out of bit 15.
- R2: Subtract (code 1) gives reg+~opnd+1 with write enable high and updates all four flags. C is the carry out of that sum, which means it is 1 exactly when reg >= opnd unsigned. V is signed overflow of reg-opnd.
- R3: Compare (code 4) drives the difference reg-opnd on result_o and sets all four flags exactly as subtract does, but holds the write enable low.
- R4: AND (code 2) and OR (code 3) write the bitwise result. Their update mask is 1100, so V and C keep their stored values.
- R5: Invert (code 5) writes ~reg with update mask 1100.
- R6: Negate (code 6) writes 0-reg with update mask 1110. V is 1 only when reg is 16'h8000.
- R7: Arithmetic shift left (code 7) writes reg<<1 with bit 0 cleared and update mask 1111. C takes old bit 15, and V is old bit 15 XOR old bit 14.
- R8: Arithmetic shift right (code 8) writes reg shifted right with bit 15 kept and update mask 1101. C takes old bit 0.
- R9: Rotate left (code 9) sends old bit 15 to C and the stored C into bit 0. Rotate right (code 10) sends old bit 0 to C and the stored C into bit 15. Both have update mask 0001 and write enable high.
- R10: Pack flags (code 11) writes {12'b0, N, Z, V, C} of the stored flags with update mask 0000.
- R11: The stored flags reset to 0000. At a rising edge with the strobe high, each flag whose mask bit is set loads its new value and the others hold. Without the strobe, all flags hold.
- R12: Reserved codes 12 to 15 give result 0, write enable low and update mask 0000.
- R13: Whenever N or Z is in the update mask, N equals bit 15 of result_o and Z is 1 exactly when result_o is zero. Flag outputs whose mask bit is clear equal the stored flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the flag file |
| op_i | input | 4 | Operation code |
| reg_i | input | 16 | Current destination register value |
| opnd_i | input | 16 | Second operand |
| flag_strobe_i | input | 1 | Load the masked flags at the next rising edge |
| result_o | output | 16 | Operation result |
| reg_we_o | output | 1 | Store result_o in the destination register |
| flag_n_o | output | 1 | Negative flag after this operation |
| flag_z_o | output | 1 | Zero flag after this operation |
| flag_v_o | output | 1 | Overflow flag after this operation |
| flag_c_o | output | 1 | Carry flag after this operation |
| flag_upd_o | output | 4 | Update mask {N,Z,V,C} |
| flags_q_o | output | 4 | Stored flags {N,Z,V,C} |

## Verification
The assertions check the following rules on every cycle:

- the update mask chosen for each operation class;
- compare never writing;
- the negate overflow rule;
- the agreement of N and Z with the result;
- the packing of the stored flags;
- the idleness of reserved codes;
- bit conservation across a rotate;
- flag-file hold when the strobe is low.

The numerical values need the bench's sweeps. These are the sums, differences and carries, the overflow decisions at the signed boundaries, and the shift and rotate results under both carry states. The bench's scenarios are also the only way to show that masked flags survive a strobed logic operation.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_CMP  = 4'd4,
        OP_INV  = 4'd5,
        OP_NEG  = 4'd6,
        OP_ASL  = 4'd7,
        OP_ASR  = 4'd8,
        OP_ROL  = 4'd9,
        OP_ROR  = 4'd10,
        OP_PACK = 4'd11,
        OP_RS12 = 4'd12,
        OP_RS13 = 4'd13,
        OP_RS14 = 4'd14,
        OP_RS15 = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    localparam int NUM_FLAGS = 4;

    localparam logic [NUM_FLAGS-1:0] UPD_ALL  = 4'b1111;
    localparam logic [NUM_FLAGS-1:0] UPD_NZ   = 4'b1100;
    localparam logic [NUM_FLAGS-1:0] UPD_NZV  = 4'b1110;
    localparam logic [NUM_FLAGS-1:0] UPD_NZC  = 4'b1101;
    localparam logic [NUM_FLAGS-1:0] UPD_C    = 4'b0001;
    localparam logic [NUM_FLAGS-1:0] UPD_NONE = 4'b0000;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;

    always_comb begin
        b_eff  = sub_i ? ~b_i : b_i;
        wide   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
        sum_o  = wide[WIDTH-1:0];
        cout_o = wide[WIDTH];
        ovf_o  = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
    end

endmodule

// File: rtl/acc_alu_shifter.sv
module acc_alu_shifter
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] val_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        res_o  = val_i;
        cout_o = cin_i;
        ovf_o  = 1'b0;
        unique case (op_i)
            OP_ASL: begin
                res_o  = {val_i[MSB-1:0], 1'b0};
                cout_o = val_i[MSB];
                ovf_o  = val_i[MSB] ^ val_i[MSB-1];
            end
            OP_ASR: begin
                res_o  = {val_i[MSB], val_i[MSB:1]};
                cout_o = val_i[0];
            end
            OP_ROL: begin
                res_o  = {val_i[MSB-1:0], cin_i};
                cout_o = val_i[MSB];
            end
            OP_ROR: begin
                res_o  = {cin_i, val_i[MSB:1]};
                cout_o = val_i[0];
            end
            default: begin
                res_o  = val_i;
                cout_o = cin_i;
                ovf_o  = 1'b0;
            end
        endcase
    end

    // R9: a rotate through carry neither creates nor loses set bits
    always_comb begin
        if (!$isunknown({op_i, val_i, cin_i}) && (op_i == OP_ROL || op_i == OP_ROR)) begin
            p_rot_bits_r9: assert ($countones({cout_o, res_o}) == $countones({cin_i, val_i}));
        end
    end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  alu_op_e                op_i,
    input  logic [WIDTH-1:0]       reg_i,
    input  logic [WIDTH-1:0]       opnd_i,
    input  flags_t                 cur_i,
    output logic [WIDTH-1:0]       result_o,
    output logic                   we_o,
    output flags_t                 next_o,
    output logic [NUM_FLAGS-1:0]   upd_o
);
    localparam int MSB = WIDTH - 1;
    localparam int PAD = WIDTH - NUM_FLAGS;

    logic [WIDTH-1:0] as_a, as_b, as_sum;
    logic             as_sub, as_c, as_v;
    logic [WIDTH-1:0] sh_res;
    logic             sh_c, sh_v;
    flags_t           calc;

    // one adder serves add, subtract, compare and negate
    always_comb begin
        as_a   = (op_i == OP_NEG) ? '0 : reg_i;
        as_b   = (op_i == OP_NEG) ? reg_i : opnd_i;
        as_sub = (op_i != OP_ADD);
    end

    acc_alu_addsub #(.WIDTH(WIDTH)) addsub_i (
        .a_i    (as_a),
        .b_i    (as_b),
        .sub_i  (as_sub),
        .sum_o  (as_sum),
        .cout_o (as_c),
        .ovf_o  (as_v)
    );

    acc_alu_shifter #(.WIDTH(WIDTH)) shifter_i (
        .op_i   (op_i),
        .val_i  (reg_i),
        .cin_i  (cur_i.c),
        .res_o  (sh_res),
        .cout_o (sh_c),
        .ovf_o  (sh_v)
    );

    always_comb begin
        result_o = '0;
        we_o     = 1'b0;
        upd_o    = UPD_NONE;
        calc.v   = 1'b0;
        calc.c   = 1'b0;
        unique case (op_i)
            OP_ADD, OP_SUB: begin
                result_o = as_sum;
                we_o     = 1'b1;
                upd_o    = UPD_ALL;
                calc.v   = as_v;
                calc.c   = as_c;
            end
            OP_CMP: begin
                result_o = as_sum;
                upd_o    = UPD_ALL;
                calc.v   = as_v;
                calc.c   = as_c;
            end
            OP_AND: begin
                result_o = reg_i & opnd_i;
                we_o     = 1'b1;
                upd_o    = UPD_NZ;
            end
            OP_OR: begin
                result_o = reg_i | opnd_i;
                we_o     = 1'b1;
                upd_o    = UPD_NZ;
            end
            OP_INV: begin
                result_o = ~reg_i;
                we_o     = 1'b1;
                upd_o    = UPD_NZ;
            end
            OP_NEG: begin
                result_o = as_sum;
                we_o     = 1'b1;
                upd_o    = UPD_NZV;
                calc.v   = as_v;
            end
            OP_ASL: begin
                result_o = sh_res;
                we_o     = 1'b1;
                upd_o    = UPD_ALL;
                calc.v   = sh_v;
                calc.c   = sh_c;
            end
            OP_ASR: begin
                result_o = sh_res;
                we_o     = 1'b1;
                upd_o    = UPD_NZC;
                calc.c   = sh_c;
            end
            OP_ROL, OP_ROR: begin
                result_o = sh_res;
                we_o     = 1'b1;
                upd_o    = UPD_C;
                calc.c   = sh_c;
            end
            OP_PACK: begin
                result_o = {{PAD{1'b0}}, cur_i};
                we_o     = 1'b1;
            end
            default: begin
                result_o = '0;
                we_o     = 1'b0;
                upd_o    = UPD_NONE;
            end
        endcase
        calc.n = result_o[MSB];
        calc.z = (result_o == '0);
    end

    // unmasked flags pass the stored value through
    always_comb begin
        next_o.n = upd_o[3] ? calc.n : cur_i.n;
        next_o.z = upd_o[2] ? calc.z : cur_i.z;
        next_o.v = upd_o[1] ? calc.v : cur_i.v;
        next_o.c = upd_o[0] ? calc.c : cur_i.c;
    end

endmodule

// File: rtl/acc_alu_flag_file.sv
module acc_alu_flag_file
    import acc_alu_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 strobe_i,
    input  logic [NUM_FLAGS-1:0] upd_i,
    input  flags_t               next_i,
    output flags_t               q_o
);
    flags_t q_d;

    always_comb begin
        q_d = q_o;
        if (strobe_i) begin
            if (upd_i[3]) q_d.n = next_i.n;
            if (upd_i[2]) q_d.z = next_i.z;
            if (upd_i[1]) q_d.v = next_i.v;
            if (upd_i[0]) q_d.c = next_i.c;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_o <= '0;
        else         q_o <= q_d;
    end

    // R11: no strobe, no change
    p_hold_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strobe_i |=> $stable(q_o));

    // R11: masked-off carry survives a strobe
    p_hold_c_masked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && !upd_i[0]) |=> $stable(q_o.c));

    // R11: masked-off overflow survives a strobe
    p_hold_v_masked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && !upd_i[1]) |=> $stable(q_o.v));

endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] reg_i,
    input  logic [WIDTH-1:0] opnd_i,
    input  logic             flag_strobe_i,
    output logic [WIDTH-1:0] result_o,
    output logic             reg_we_o,
    output logic             flag_n_o,
    output logic             flag_z_o,
    output logic             flag_v_o,
    output logic             flag_c_o,
    output logic [3:0]       flag_upd_o,
    output logic [3:0]       flags_q_o
);
    localparam int MSB = WIDTH - 1;
    localparam int PAD = WIDTH - NUM_FLAGS;
    localparam logic [WIDTH-1:0] MIN_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    alu_op_e              op;
    flags_t               cur, nxt;
    logic [NUM_FLAGS-1:0] upd;

    assign op = alu_op_e'(op_i);

    acc_alu_core #(.WIDTH(WIDTH)) core_i (
        .op_i     (op),
        .reg_i    (reg_i),
        .opnd_i   (opnd_i),
        .cur_i    (cur),
        .result_o (result_o),
        .we_o     (reg_we_o),
        .next_o   (nxt),
        .upd_o    (upd)
    );

    acc_alu_flag_file flags_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .strobe_i (flag_strobe_i),
        .upd_i    (upd),
        .next_i   (nxt),
        .q_o      (cur)
    );

    assign flag_n_o   = nxt.n;
    assign flag_z_o   = nxt.z;
    assign flag_v_o   = nxt.v;
    assign flag_c_o   = nxt.c;
    assign flag_upd_o = upd;
    assign flags_q_o  = cur;

    p_cmp_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op == OP_CMP) |-> (!reg_we_o && flag_upd_o == 4'b1111));

    p_logic_keeps_vc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op == OP_AND || op == OP_OR) |-> (flag_upd_o == 4'b1100 && flag_v_o == cur.v && flag_c_o == cur.c));

    p_neg_ovf_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op == OP_NEG) |-> (flag_v_o == (reg_i == MIN_NEG)));

    p_rot_only_c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op == OP_ROL || op == OP_ROR) |-> (flag_upd_o == 4'b0001 && {flag_n_o, flag_z_o, flag_v_o} == {cur.n, cur.z, cur.v}));

    p_pack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op == OP_PACK) |-> (result_o == {{PAD{1'b0}}, flags_q_o} && flag_upd_o == 4'b0000));

    p_reserved_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i >= 4'd12) |-> (!reg_we_o && flag_upd_o == 4'b0000 && result_o == '0));

    p_nz_track_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_upd_o[2] |-> (flag_z_o == (result_o == '0) && flag_n_o == result_o[MSB]));

endmodule

// File: tb/acc_alu_unit_tb_top.sv
module acc_alu_unit_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic [15:0] reg_i = 16'd0;
    logic [15:0] opnd_i = 16'd0;
    logic        flag_strobe_i = 1'b0;
    logic [15:0] result_o;
    logic        reg_we_o;
    logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o;
    logic [3:0]  flag_upd_o;
    logic [3:0]  flags_q_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    logic [3:0]  mq = 4'b0000;  // bench copy of stored flags {N,Z,V,C}
    logic [15:0] e_res;
    logic        e_we;
    logic [3:0]  e_upd;
    logic [3:0]  e_flags;

    logic [15:0] vals [10] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFE, 16'h7FFF,
                               16'h8000, 16'h8001, 16'h5555, 16'hAAAA, 16'hFFFF};

    always #4 clk_i = ~clk_i;

    acc_alu_unit #(.WIDTH(16)) dut_i (
        .clk_i (clk_i), .rst_ni (rst_ni), .op_i (op_i), .reg_i (reg_i), .opnd_i (opnd_i),
        .flag_strobe_i (flag_strobe_i), .result_o (result_o), .reg_we_o (reg_we_o),
        .flag_n_o (flag_n_o), .flag_z_o (flag_z_o), .flag_v_o (flag_v_o), .flag_c_o (flag_c_o),
        .flag_upd_o (flag_upd_o), .flags_q_o (flags_q_o)
    );

    function automatic string tag_of(input int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2, 3: return "R4";
            4: return "R3";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            9, 10: return "R9";
            11: return "R10";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h (op=%0d reg=%h opnd=%h)",
                     tag, what, act, exp, op_i, reg_i, opnd_i);
        end
    endtask

    function automatic bit out_of_range(input int t);
        return (t > 32767) || (t < -32768);
    endfunction

    // expected outputs from the requirements, independent of the design
    task automatic model(input int op, input int r, input int o);
        int sr, so, res, c, v, upd, we, nf, zf;
        int cin;
        sr = (r >= 32768) ? r - 65536 : r;
        so = (o >= 32768) ? o - 65536 : o;
        cin = int'(mq[0]);
        res = 0; c = 0; v = 0; upd = 0; we = 1;
        case (op)
            0: begin res = (r + o) & 16'hFFFF; c = int'(r + o > 65535);
                     v = int'(out_of_range(sr + so)); upd = 4'b1111; end
            1, 4: begin res = (r - o) & 16'hFFFF; c = int'(r >= o);
                     v = int'(out_of_range(sr - so)); upd = 4'b1111; we = int'(op == 1); end
            2: begin res = r & o; upd = 4'b1100; end
            3: begin res = r | o; upd = 4'b1100; end
            5: begin res = (~r) & 16'hFFFF; upd = 4'b1100; end
            6: begin res = (65536 - r) & 16'hFFFF; v = int'(r == 32768); upd = 4'b1110; end
            7: begin res = (r * 2) & 16'hFFFF; c = int'(r >= 32768);
                     v = int'(out_of_range(sr * 2)); upd = 4'b1111; end
            8: begin res = (r >> 1) | (r & 32768); c = r & 1; upd = 4'b1101; end
            9: begin res = ((r * 2) | cin) & 16'hFFFF; c = int'(r >= 32768); upd = 4'b0001; end
            10: begin res = (r >> 1) | (cin * 32768); c = r & 1; upd = 4'b0001; end
            11: begin res = int'(mq); upd = 0; end
            default: begin res = 0; we = 0; upd = 0; end
        endcase
        nf = int'(res >= 32768);
        zf = int'(res == 0);
        e_res = 16'(res);
        e_we  = we[0];
        e_upd = 4'(upd);
        e_flags[3] = upd[3] ? nf[0] : mq[3];
        e_flags[2] = upd[2] ? zf[0] : mq[2];
        e_flags[1] = upd[1] ? v[0]  : mq[1];
        e_flags[0] = upd[0] ? c[0]  : mq[0];
    endtask

    task automatic apply(input int op, input logic [15:0] r, input logic [15:0] o);
        @(negedge clk_i);
        op_i = 4'(op); reg_i = r; opnd_i = o;
        #1;
        model(op, int'(r), int'(o));
        check(tag_of(op), "result/we", {reg_we_o, result_o}, {e_we, e_res});
        check(tag_of(op), "V/C/mask", {flag_v_o, flag_c_o, flag_upd_o}, {e_flags[1:0], e_upd});
        check("R13", "N/Z", {flag_n_o, flag_z_o}, e_flags[3:2]);
    endtask

    task automatic strobe_op(input int op, input logic [15:0] r, input logic [15:0] o);
        apply(op, r, o);
        flag_strobe_i = 1'b1;
        @(posedge clk_i);
        mq = e_flags;
        @(negedge clk_i);
        flag_strobe_i = 1'b0;
        check("R11", "stored flags after strobe", flags_q_o, mq);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        check("R11", "reset flags", flags_q_o, 4'b0000);
        rst_ni = 1'b1;
        @(negedge clk_i);

        // sweep under two known stored-flag states: C=1 then C=0
        for (int pass = 0; pass < 2; pass++) begin
            if (pass == 0) strobe_op(0, 16'hFFFF, 16'h0001);  // Z=1 C=1
            else           strobe_op(0, 16'h7FFF, 16'h0001);  // N=1 V=1 C=0
            for (int op = 0; op < 16; op++)
                for (int i = 0; i < 10; i++)
                    for (int j = 0; j < 10; j++)
                        apply(op, vals[i], vals[j]);
            // R11: no strobe across the sweep, stored flags unchanged
            check("R11", "hold without strobe", flags_q_o, mq);
        end

        // R11/R4: a strobed AND keeps stored V and C
        strobe_op(7, 16'hC000, 16'h0000);   // ASL: C=1, V=0, N=1
        strobe_op(0, 16'h7FFF, 16'h0001);   // V=1 C=0
        strobe_op(2, 16'h0F0F, 16'hF0F0);   // AND -> zero, V/C kept
        check("R4", "V/C kept by AND", flags_q_o[1:0], 2'b10);
        // R10: pack reflects these stored flags
        apply(11, 16'h1234, 16'h5678);
        check("R10", "pack value", result_o, 16'h0006);
        // R9: rotate chain through carry
        strobe_op(9, 16'h8001, 16'h0000);
        strobe_op(10, 16'h0002, 16'h0000);
        // R3: compare with strobe leaves write low but loads flags
        strobe_op(4, 16'h0003, 16'h0005);
        // R12: reserved code with strobe changes nothing
        strobe_op(13, 16'hFFFF, 16'hFFFF);
        // R6, R8 boundary with strobe
        strobe_op(6, 16'h8000, 16'h0000);
        strobe_op(8, 16'h8001, 16'h0000);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule